// File: doc/BRIEF.md
# DSL Transmit Frame Assembler

This block builds the transmit side of a fixed-length DSL frame and sends it as a serial bit stream. A frame has 48 payload blocks. Each block is one Z overhead bit followed by N payload octets. The blocks are sent in four groups of twelve. A sync word, three overhead words and a short stuff field are placed between the groups. At N = 12 a frame holds 4704 bits, which is 6 ms at 784 kbps. At N = 18 the frame holds 7008 bits, which is 6 ms at 1168 kbps. N is fixed at elaboration.

The line-rate clock enable `bitEn` sets the pace: each qualified clock edge moves one bit. Before a bit is emitted, the assembler asks for it from the surrounding logic:
- Payload octets come from a parallel source. A one-clock request strobe fires one bit-time before each octet is needed.
- Z bits are read from `zBit` while `blockIdx` names the current block.
- Overhead words are read from `ohWord` while `ohIdx` names the current overhead field.
- The sync word and the stuff bits are plain inputs.

The output stays quiet until the run control is seen. After that, frames follow one another without a gap.

Top module: `dsl_tx_framer`

## Requirements
- R1: During reset, and after reset until `runEn` has been registered, `txBit`, `frameStart` and `byteReq` are all 0, whatever `bitEn` does.
- R2: The first rising edge with `bitEn` high after the edge that registers `runEn` high emits the first sync bit. In the clock that follows, `frameStart` is 1 for exactly one clock, alongside that bit on `txBit`.
- R3: A frame is exactly 48·(1+8·N) + 14 + 3·10 + 4 emitted bits long, which is 4704 at N = 12. `frameStart` repeats every frame length of emitted bits.
- R4: The frame is laid out in this order: sync (14 bits), OH0 (10), blocks 0–11, OH1 (10), blocks 12–23, OH2 (10), blocks 24–35, stuff (4), blocks 36–47.
- R5: Each block sends its Z bit first and then N octets, each octet MSB first. The Z bit is the value of `zBit` sampled while `blockIdx` equals the block number (0–47).
- R6: `byteReq` is a one-clock pulse. It follows every edge that emits the bit just before a payload octet. The edge that emits that octet's first bit samples `payByte`/`payValid`. There are 48·N pulses per frame.
- R7: If `payValid` is 0 when an octet is sampled, that octet is sent as 0xFF.
- R8: Sync, overhead and stuff fields are sent MSB first. Each overhead word is sampled on its field's first bit from `ohWord`, with `ohIdx` = 0, 1 or 2 naming OH0, OH1 or OH2.
- R9: A clock edge with `bitEn` low changes neither `txBit` nor the frame position.
- R10: Once running, frames keep going back to back even after `runEn` returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitEn | input | 1 | Line bit-rate enable; one bit moves per qualified edge |
| runEn | input | 1 | Run control; registered, sticky once seen |
| syncPattern | input | 14 | Sync word, MSB sent first |
| ohWord | input | 10 | Overhead word for the field named by `ohIdx` |
| ohIdx | output | 2 | Index of the current or next overhead field |
| stuffBits | input | 4 | Stuff field value, MSB sent first |
| zBit | input | 1 | Z bit for the block named by `blockIdx` |
| blockIdx | output | 6 | Number of the current or next block in the frame (0–47) |
| payByte | input | 8 | Payload octet |
| payValid | input | 1 | Payload octet valid; 0 makes the octet 0xFF |
| byteReq | output | 1 | Payload octet request, one bit-time ahead |
| txBit | output | 1 | Serial frame output |
| frameStart | output | 1 | One-clock marker with the first sync bit |

## Verification
The assertions check the following properties on every cycle:
- silence before run;
- the run state staying set;
- `txBit` holding on idle edges;
- request pulses lasting one clock and never coinciding with a frame marker;
- the stuff field only appearing in the last group gap;
- the sync field only starting at block zero.

Other properties can only be shown by the bench's scenarios, because they need a reference deserializer that follows the whole frame:
- the exact frame length;
- the place of every field;
- MSB-first ordering;
- the 0xFF substitution;
- the start timing after run.

The scenarios cover a continuous enable, sparse random enables, and all-invalid or mixed payload.

// File: rtl/dsl_tx_framer_pkg.sv
package dsl_tx_framer_pkg;

  typedef enum logic [1:0] {
    SEG_SYNC,
    SEG_OH,
    SEG_BLK,
    SEG_STUFF
  } seg_t;

  typedef enum logic [2:0] {
    SRC_SYNC,
    SRC_OH,
    SRC_STUFF,
    SRC_Z,
    SRC_PAY
  } src_t;

  // Control-to-datapath strobes for the bit about to be emitted.
  typedef struct packed {
    src_t src;        // which input feeds this bit
    logic load;       // first bit of a multi-bit field: load the shifter
    logic preOct;     // this bit immediately precedes a payload octet
    logic frameHead;  // first bit of the frame
  } strobe_t;

endpackage

// File: rtl/dsl_tx_framer_ctrl.sv
module dsl_tx_framer_ctrl
  import dsl_tx_framer_pkg::*;
#(
  parameter int N_OCT       = 12,
  parameter int SYNC_W      = 14,
  parameter int OH_W        = 10,
  parameter int STUFF_W     = 4,
  parameter int BLK_PER_GRP = 12,
  parameter int NUM_GRP     = 4,
  localparam int OHIDX_W    = (NUM_GRP > 2) ? $clog2(NUM_GRP - 1) : 1,
  localparam int BLKIDX_W   = $clog2(BLK_PER_GRP * NUM_GRP)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                adv,
  output strobe_t             strb,
  output logic [OHIDX_W-1:0]  ohIdx,
  output logic [BLKIDX_W-1:0] blockIdx
);

  localparam int BLK_LAST_I = 8 * N_OCT;
  localparam int MAX_A      = (SYNC_W > OH_W) ? SYNC_W : OH_W;
  localparam int MAX_B      = (STUFF_W > BLK_LAST_I + 1) ? STUFF_W : BLK_LAST_I + 1;
  localparam int MAX_LEN    = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W      = $clog2(MAX_LEN + 1);
  localparam int BIG_W      = (BLK_PER_GRP > 1) ? $clog2(BLK_PER_GRP) : 1;
  localparam int GRP_W      = $clog2(NUM_GRP);

  localparam logic [CNT_W-1:0] SYNC_LAST  = CNT_W'(SYNC_W - 1);
  localparam logic [CNT_W-1:0] OH_LAST    = CNT_W'(OH_W - 1);
  localparam logic [CNT_W-1:0] STUFF_LAST = CNT_W'(STUFF_W - 1);
  localparam logic [CNT_W-1:0] BLK_LAST   = CNT_W'(BLK_LAST_I);
  localparam logic [BIG_W-1:0] BIG_LAST   = BIG_W'(BLK_PER_GRP - 1);
  localparam logic [GRP_W-1:0] GRP_LAST   = GRP_W'(NUM_GRP - 1);
  localparam logic [GRP_W-1:0] GRP_PREST  = GRP_W'(NUM_GRP - 2);

  seg_t             seg;
  logic [CNT_W-1:0] bitIdx;
  logic [BIG_W-1:0] blkInGrp;
  logic [GRP_W-1:0] grp;
  logic [CNT_W-1:0] lastBit;
  logic             fieldEnd;
  logic             grpEnd;

  always_comb begin
    case (seg)
      SEG_SYNC:  lastBit = SYNC_LAST;
      SEG_OH:    lastBit = OH_LAST;
      SEG_STUFF: lastBit = STUFF_LAST;
      default:   lastBit = BLK_LAST;
    endcase
    fieldEnd = (bitIdx == lastBit);
    grpEnd   = (blkInGrp == BIG_LAST);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      seg      <= SEG_SYNC;
      bitIdx   <= '0;
      blkInGrp <= '0;
      grp      <= '0;
    end else if (adv) begin
      if (!fieldEnd) begin
        bitIdx <= bitIdx + 1'b1;
      end else begin
        bitIdx <= '0;
        case (seg)
          SEG_SYNC:  seg <= SEG_OH;
          SEG_OH:    seg <= SEG_BLK;
          SEG_STUFF: seg <= SEG_BLK;
          default: begin
            if (!grpEnd) begin
              blkInGrp <= blkInGrp + 1'b1;
            end else begin
              blkInGrp <= '0;
              if (grp == GRP_LAST) begin
                grp <= '0;
                seg <= SEG_SYNC;
              end else begin
                grp <= grp + 1'b1;
                seg <= (grp == GRP_PREST) ? SEG_STUFF : SEG_OH;
              end
            end
          end
        endcase
      end
    end
  end

  always_comb begin
    strb = '0;
    case (seg)
      SEG_SYNC:  strb.src = SRC_SYNC;
      SEG_OH:    strb.src = SRC_OH;
      SEG_STUFF: strb.src = SRC_STUFF;
      default:   strb.src = (bitIdx == '0) ? SRC_Z : SRC_PAY;
    endcase
    if (seg == SEG_BLK) begin
      strb.load   = (bitIdx != '0) && (bitIdx[2:0] == 3'd1);
      strb.preOct = (bitIdx[2:0] == 3'd0) && (bitIdx != BLK_LAST);
    end else begin
      strb.load   = (bitIdx == '0);
      strb.preOct = 1'b0;
    end
    strb.frameHead = (seg == SEG_SYNC) && (bitIdx == '0);
  end

  assign ohIdx    = (grp < GRP_LAST) ? OHIDX_W'(grp) : OHIDX_W'(NUM_GRP - 2);
  assign blockIdx = BLKIDX_W'(grp) * BLKIDX_W'(BLK_PER_GRP) + BLKIDX_W'(blkInGrp);

  // R3: the position counter never runs past the end of its field
  assert_field_bound_R3: assert property (@(posedge clk) disable iff (!rstN)
    bitIdx <= lastBit);

  // R4: the stuff field only sits in front of the last group
  assert_stuff_slot_R4: assert property (@(posedge clk) disable iff (!rstN)
    (seg == SEG_STUFF) |-> (grp == GRP_LAST));

  // R4: the sync field only starts a frame, at block zero
  assert_sync_head_R4: assert property (@(posedge clk) disable iff (!rstN)
    (seg == SEG_SYNC) |-> (grp == '0 && blkInGrp == '0));

  // R4: the last bit of a group hands over to a non-block field
  assert_group_close_R4: assert property (@(posedge clk) disable iff (!rstN)
    (adv && seg == SEG_BLK && fieldEnd && grpEnd) |=> (seg != SEG_BLK));

endmodule

// File: rtl/dsl_tx_framer_dp.sv
module dsl_tx_framer_dp
  import dsl_tx_framer_pkg::*;
#(
  parameter int SYNC_W  = 14,
  parameter int OH_W    = 10,
  parameter int STUFF_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               adv,
  input  strobe_t            strb,
  input  logic [SYNC_W-1:0]  syncPattern,
  input  logic [OH_W-1:0]    ohWord,
  input  logic [STUFF_W-1:0] stuffBits,
  input  logic               zBit,
  input  logic [7:0]         payByte,
  input  logic               payValid,
  output logic               txBit,
  output logic               frameStart,
  output logic               byteReq
);

  localparam int SHW_A = (SYNC_W > OH_W) ? SYNC_W : OH_W;
  localparam int SHW_B = (STUFF_W > 8) ? STUFF_W : 8;
  localparam int SHW   = (SHW_A > SHW_B) ? SHW_A : SHW_B;

  logic [SHW-1:0] shReg;
  logic [SHW-1:0] loadWord;
  logic [7:0]     payOct;

  always_comb begin
    payOct = payValid ? payByte : 8'hFF;
    case (strb.src)
      SRC_SYNC:  loadWord = SHW'(syncPattern) << (SHW - SYNC_W);
      SRC_OH:    loadWord = SHW'(ohWord) << (SHW - OH_W);
      SRC_STUFF: loadWord = SHW'(stuffBits) << (SHW - STUFF_W);
      SRC_PAY:   loadWord = SHW'(payOct) << (SHW - 8);
      default:   loadWord = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txBit      <= 1'b0;
      frameStart <= 1'b0;
      byteReq    <= 1'b0;
      shReg      <= '0;
    end else begin
      frameStart <= adv && strb.frameHead;
      byteReq    <= adv && strb.preOct;
      if (adv) begin
        if (strb.src == SRC_Z) begin
          txBit <= zBit;
        end else if (strb.load) begin
          txBit <= loadWord[SHW-1];
          shReg <= loadWord << 1;
        end else begin
          txBit <= shReg[SHW-1];
          shReg <= shReg << 1;
        end
      end
    end
  end

  // R6: a request and a frame marker never share a clock
  assert_req_apart_R6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({frameStart, byteReq}));

  // R6: a request lasts a single clock
  assert_req_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    byteReq |=> !byteReq);

endmodule

// File: rtl/dsl_tx_framer.sv
module dsl_tx_framer
  import dsl_tx_framer_pkg::*;
#(
  parameter int N_OCT       = 12,
  parameter int SYNC_W      = 14,
  parameter int OH_W        = 10,
  parameter int STUFF_W     = 4,
  parameter int BLK_PER_GRP = 12,
  parameter int NUM_GRP     = 4,
  localparam int OHIDX_W    = (NUM_GRP > 2) ? $clog2(NUM_GRP - 1) : 1,
  localparam int BLKIDX_W   = $clog2(BLK_PER_GRP * NUM_GRP)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                bitEn,
  input  logic                runEn,
  input  logic [SYNC_W-1:0]   syncPattern,
  input  logic [OH_W-1:0]     ohWord,
  output logic [OHIDX_W-1:0]  ohIdx,
  input  logic [STUFF_W-1:0]  stuffBits,
  input  logic                zBit,
  output logic [BLKIDX_W-1:0] blockIdx,
  input  logic [7:0]          payByte,
  input  logic                payValid,
  output logic                byteReq,
  output logic                txBit,
  output logic                frameStart
);

  logic    running;
  logic    adv;
  strobe_t strb;

  always_ff @(posedge clk) begin
    if (!rstN) running <= 1'b0;
    else       running <= running | runEn;
  end

  assign adv = running && bitEn;

  dsl_tx_framer_ctrl #(
    .N_OCT(N_OCT), .SYNC_W(SYNC_W), .OH_W(OH_W), .STUFF_W(STUFF_W),
    .BLK_PER_GRP(BLK_PER_GRP), .NUM_GRP(NUM_GRP)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .adv(adv), .strb(strb),
    .ohIdx(ohIdx), .blockIdx(blockIdx)
  );

  dsl_tx_framer_dp #(
    .SYNC_W(SYNC_W), .OH_W(OH_W), .STUFF_W(STUFF_W)
  ) i_dp (
    .clk(clk), .rstN(rstN), .adv(adv), .strb(strb),
    .syncPattern(syncPattern), .ohWord(ohWord), .stuffBits(stuffBits),
    .zBit(zBit), .payByte(payByte), .payValid(payValid),
    .txBit(txBit), .frameStart(frameStart), .byteReq(byteReq)
  );

  // R1: nothing leaves the block before the run state is set
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    !running |-> (!txBit && !frameStart && !byteReq));

  // R10: the run state is never cleared outside reset
  assert_run_sticky_R10: assert property (@(posedge clk) disable iff (!rstN)
    running |=> running);

  // R9: an edge without the bit enable leaves the serial output alone
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !adv |=> $stable(txBit));

endmodule

// File: tb/test_dsl_tx_framer.sv
module test_dsl_tx_framer;

  localparam int N_OCT      = 12;
  localparam int SYNC_W     = 14;
  localparam int OH_W       = 10;
  localparam int STUFF_W    = 4;
  localparam int NBLK       = 48;
  localparam int BLK_BITS   = 1 + 8 * N_OCT;
  localparam int FRAME_BITS = NBLK * BLK_BITS + SYNC_W + 3 * OH_W + STUFF_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bitEn = 1'b0;
  logic runEn = 1'b0;
  logic [SYNC_W-1:0]  syncPattern;
  logic [OH_W-1:0]    ohWord;
  logic [1:0]         ohIdx;
  logic [STUFF_W-1:0] stuffBits;
  logic               zBit;
  logic [5:0]         blockIdx;
  logic [7:0]         payByte;
  logic               payValid;
  logic               byteReq, txBit, frameStart;

  logic [OH_W-1:0] ohVals [3];
  logic [47:0]     zPat;

  always #4 clk = ~clk;

  always_comb ohWord = (ohIdx < 2'd3) ? ohVals[ohIdx] : '0;
  always_comb zBit   = zPat[blockIdx];

  dsl_tx_framer i_dsl_tx_framer (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .runEn(runEn),
    .syncPattern(syncPattern), .ohWord(ohWord), .ohIdx(ohIdx),
    .stuffBits(stuffBits), .zBit(zBit), .blockIdx(blockIdx),
    .payByte(payByte), .payValid(payValid), .byteReq(byteReq),
    .txBit(txBit), .frameStart(frameStart)
  );

  int checks = 0;
  int fails  = 0;

  // bench state
  int   fpos = -1;
  int   frameNo = 0;
  int   framesDone = 0;
  int   framesAfterDrop = 0;
  int   enPct = 100;
  int   validPct = 100;
  bit   advPrev = 0;
  bit   runSeen = 0;
  bit   firstAdvDone = 0;
  bit   reqPrev = 0;
  logic lastTx = 1'b0;
  logic [8:0] expQ [$];
  logic [8:0] curOct;
  int eSync, eOh, eZ, ePay, ePayInv, eStuff, eHold, reqCnt, eReqPulse;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Independent layout model: kind 0 sync, 1 OH, 2 Z, 3 payload, 4 stuff
  function automatic void decode(input int q, output int kind, output int idx, output int b);
    int p;
    p = q; kind = -1; idx = 0; b = 0;
    if (p < SYNC_W) begin kind = 0; b = p; return; end
    p -= SYNC_W;
    for (int g = 0; g < 4; g++) begin
      if (g < 3) begin
        if (p < OH_W) begin kind = 1; idx = g; b = p; return; end
        p -= OH_W;
      end else begin
        if (p < STUFF_W) begin kind = 4; b = p; return; end
        p -= STUFF_W;
      end
      if (p < 12 * BLK_BITS) begin
        idx  = g * 12 + p / BLK_BITS;
        b    = p % BLK_BITS;
        kind = (b == 0) ? 2 : 3;
        return;
      end
      p -= 12 * BLK_BITS;
    end
  endfunction

  task automatic finishFrame();
    check(fpos == FRAME_BITS, "R3", "frame bit count", fpos, FRAME_BITS);
    check(eSync == 0,  "R8", "sync bit mismatches", eSync, 0);
    check(eOh == 0,    "R4", "overhead field mismatches", eOh, 0);
    check(eStuff == 0, "R4", "stuff field mismatches", eStuff, 0);
    check(eZ == 0,     "R5", "Z bit mismatches", eZ, 0);
    check(ePay == 0,   "R5", "payload bit mismatches", ePay, 0);
    check(ePayInv == 0, "R7", "invalid-octet bit mismatches", ePayInv, 0);
    check(reqCnt == NBLK * N_OCT, "R6", "byte requests per frame", reqCnt, NBLK * N_OCT);
    check(eReqPulse == 0, "R6", "request pulses longer than a clock", eReqPulse, 0);
    check(eHold == 0,  "R9", "output changes on idle edges", eHold, 0);
    framesDone++;
  endtask

  task automatic newFrame();
    fpos = 0;
    eSync = 0; eOh = 0; eZ = 0; ePay = 0; ePayInv = 0; eStuff = 0;
    eHold = 0; reqCnt = 0; eReqPulse = 0;
    for (int k = 0; k < 3; k++) ohVals[k] = OH_W'($urandom);
    zPat      = {16'($urandom), 32'($urandom)};
    stuffBits = STUFF_W'($urandom);
    case (frameNo)
      0: begin enPct = 100; validPct = 100; end
      1: begin enPct = 50;  validPct = 75;  end
      2: begin enPct = 70;  validPct = 0;   end
      default: begin enPct = 40; validPct = 50; end
    endcase
    if (frameNo == 1) runEn = 1'b0;   // R10: drop the run control mid-stream
    if (frameNo >= 1) framesAfterDrop++;
    frameNo++;
  endtask

  task automatic observe();
    int kind, idx, b, ob;
    logic expBit;
    if (advPrev) begin
      if (!firstAdvDone) begin
        firstAdvDone = 1;
        check(frameStart == 1'b1, "R2", "frameStart on first advance", frameStart, 1);
        check(txBit == syncPattern[SYNC_W-1], "R2", "first sync bit", txBit, syncPattern[SYNC_W-1]);
      end
      if (frameStart) begin
        if (fpos >= 0) finishFrame();
        newFrame();
      end
      if (fpos >= 0) begin
        if (fpos < FRAME_BITS) begin
          decode(fpos, kind, idx, b);
          case (kind)
            0: begin expBit = syncPattern[SYNC_W-1-b]; if (txBit !== expBit) eSync++; end
            1: begin expBit = ohVals[idx][OH_W-1-b];   if (txBit !== expBit) eOh++; end
            4: begin expBit = stuffBits[STUFF_W-1-b];  if (txBit !== expBit) eStuff++; end
            2: begin expBit = zPat[idx];               if (txBit !== expBit) eZ++; end
            default: begin
              ob = (b - 1) % 8;
              if (ob == 0) begin
                if (expQ.size() == 0) begin ePay++; curOct = 9'h1FF; end
                else curOct = expQ.pop_front();
              end
              expBit = curOct[7-ob];
              if (txBit !== expBit) begin
                if (curOct[8]) ePay++; else ePayInv++;
              end
            end
          endcase
        end
        fpos++;
      end
    end else if (fpos >= 0) begin
      if (txBit !== lastTx || frameStart) eHold++;
    end
    lastTx = txBit;
    if (byteReq) begin
      logic [7:0] nb;
      logic       nv;
      if (reqPrev) eReqPulse++;
      reqCnt++;
      nb = 8'($urandom);
      nv = (($urandom % 100) < validPct);
      payByte  = nb;
      payValid = nv;
      expQ.push_back({nv, nv ? nb : 8'hFF});
    end
    reqPrev = byteReq;
  endtask

  task automatic drive();
    bitEn   = (($urandom % 100) < enPct);
    advPrev = runSeen && bitEn;
    runSeen = runSeen | runEn;
  endtask

  initial begin
    int cyc;
    int idleBad;
    void'($urandom(32'h5EED_0D51));
    syncPattern = 14'h2C6B;
    for (int k = 0; k < 3; k++) ohVals[k] = OH_W'($urandom);
    zPat = '0; stuffBits = '0; payByte = '0; payValid = 1'b0;

    // R1: reset state
    repeat (3) @(negedge clk);
    check(txBit == 0 && frameStart == 0 && byteReq == 0, "R1", "outputs during reset",
          {txBit, frameStart, byteReq}, 0);
    rstN = 1'b1;

    // R1: idle with random bit enables and no run
    idleBad = 0;
    for (int i = 0; i < 40; i++) begin
      bitEn = 1'($urandom);
      @(negedge clk);
      if (txBit || frameStart || byteReq) idleBad++;
    end
    check(idleBad == 0, "R1", "activity before run", idleBad, 0);

    // start: runEn registered at the next edge, first advance one edge later
    runEn = 1'b1;
    enPct = 100;
    drive();
    cyc = 0;
    while (framesDone < 4 && cyc < 150000) begin
      @(negedge clk);
      observe();
      drive();
      cyc++;
    end
    check(cyc < 150000, "R3", "watchdog: frames completed", framesDone, 4);
    check(framesAfterDrop >= 3, "R10", "frames started after run dropped", framesAfterDrop, 3);
    check(runEn == 1'b0, "R10", "run control low during later frames", runEn, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule